// File: doc/BRIEF.md
# Auto-Feeding Guard Watchdog

This block is a secondary watchdog that watches over a main system that may hang. It counts clock cycles from the last feed. At three quarters of a fixed timeout it raises a feed-request interrupt. If nothing feeds it before the full timeout, it drives a system reset pulse of programmable width and sets a sticky fired flag. Software feeds it by writing a kick bit. When auto-feed is enabled, the hardware instead feeds it itself at the moment the feed-request interrupt is raised, so the reset never occurs.

Control sits in a small memory-mapped register set. Writes to the control register take effect only while a lock register holds the unlock key. The controller has four states. OFF means halted. RUN means counting below the warning point. WARN means past the warning point with the interrupt raised. FIRE means the reset pulse is being driven. The transitions are:
- ENABLE: OFF to RUN, when halt is clear.
- HALT: any state to OFF.
- KICK: RUN or WARN to RUN, with the count set to zero.
- AUTO: RUN to RUN at the warning point, with the count set to zero.
- ALARM: RUN to WARN at the warning point, when auto-feed is off.
- EXPIRE: WARN to FIRE at the last count.
- DONE: FIRE to RUN, when the pulse ends.

Top module: `guard_wdt`

## Requirements
- R1: After reset, sys_rst_o and irq_o are 0. STATUS (address 1) reads 0. LOCK (address 2) reads 0. CTRL (address 0) reads halt (bit 0) = 0, auto-feed (bit 1) = 0, and pulse length (bits 11:2) = INIT_LEN.
- R2: A CTRL write changes nothing unless the 32-bit LOCK register holds UNLOCK_KEY. LOCK is always writable. LOCK bit 0 reads 1 while unlocked.
- R3: The feed-request interrupt is a level on irq_o, mirrored in STATUS bit 1. It rises exactly 3/4·2^CNT_W cycles after the clock edge that accepted the last feed, or after the first edge of the RUN state that follows a halt.
- R4: With no feed, sys_rst_o rises exactly 2^CNT_W cycles after the last feed and stays high for the pulse length in cycles. A length of 0 gives 1 cycle. Counting then restarts from zero, so an unfed watchdog fires again after a further 2^CNT_W cycles.
- R5: Writing 1 to CTRL bit 12 (kick) restarts the count from zero and clears the interrupt. A kick while the interrupt is pending prevents the reset.
- R6: With auto-feed set, the count restarts at the warning point. The interrupt is raised, but no reset pulse is ever driven.
- R7: STATUS bit 0 (fired flag) is set when the reset pulse starts. It stays set until 1 is written to CTRL bit 13 (flag clear). If a set and a clear fall in the same cycle, the set wins.
- R8: The kick and flag-clear bits act as single-cycle pulses and always read back as 0.
- R9: While halt is set, nothing counts, the interrupt is cleared, and no reset pulse is driven.
- R10: Writes to STATUS have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, accepted at the clock edge |
| addr | input | ADDR_W | Register address (0 CTRL, 1 STATUS, 2 LOCK) |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Combinational read data for addr |
| irq_o | output | 1 | Feed-request interrupt level |
| sys_rst_o | output | 1 | System reset pulse, active high |

## Verification
The bound checker checks the following on every cycle:
- A kick never coincides with a reset decision.
- A reset only starts while the interrupt is pending, and its first cycle follows the expire decision.
- The fired flag holds until it is cleared.
- Halt silences both outputs.
- A locked CTRL write leaves the control fields unchanged.

The exact cycle distances need the bench's scenarios. These are the warning point and the timeout after a feed, the pulse length including the zero case, the restart after a pulse, the one-cycle delay after leaving halt, and the suppression of the reset under auto-feed. The bench measures these against a scoreboard of predicted events.

// File: rtl/guard_wdt_pkg.sv
package guard_wdt_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_RUN  = 2'd1,
        ST_WARN = 2'd2,
        ST_FIRE = 2'd3
    } gwdt_state_e;

    localparam int ADDR_CTRL   = 0;
    localparam int ADDR_STATUS = 1;
    localparam int ADDR_LOCK   = 2;

    localparam int CTRL_HALT_B  = 0;
    localparam int CTRL_AUTO_B  = 1;
    localparam int CTRL_LEN_LSB = 2;

    localparam int STAT_FLAG_B = 0;
    localparam int STAT_IRQ_B  = 1;

endpackage

// File: rtl/guard_wdt_pulse.sv
module guard_wdt_pulse #(
    parameter int PULSE_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PULSE_W-1:0] len,
    output logic               last
);

    localparam logic [PULSE_W-1:0] ONE = PULSE_W'(1);

    logic [PULSE_W-1:0] rem_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= (len == '0) ? ONE : len;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - ONE;
        end
    end

    assign last = (rem_q == ONE);

endmodule

// File: rtl/guard_wdt_fsm.sv
module guard_wdt_fsm
    import guard_wdt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic halt,
    input  logic auto_feed,
    input  logic kick,
    input  logic pulse_last,
    output logic warn_set,
    output logic fire_set,
    output logic sys_rst
);

    localparam logic [CNT_W-1:0] WARN_LAST = {2'b10, {(CNT_W-2){1'b1}}};
    localparam logic [CNT_W-1:0] CNT_LAST  = '1;
    localparam logic [CNT_W-1:0] CNT_ONE   = CNT_W'(1);

    gwdt_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic hit_warn, hit_end, auto_hit, counting;

    assign hit_warn = (cnt_q == WARN_LAST);
    assign hit_end  = (cnt_q == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!halt) state_d = ST_RUN;                     // ENABLE
            end
            ST_RUN: begin
                if (halt)                        state_d = ST_OFF;  // HALT
                else if (kick)                   state_d = ST_RUN;  // KICK
                else if (hit_warn && !auto_feed) state_d = ST_WARN; // ALARM
            end
            ST_WARN: begin
                if (halt)         state_d = ST_OFF;  // HALT
                else if (kick)    state_d = ST_RUN;  // KICK
                else if (hit_end) state_d = ST_FIRE; // EXPIRE
            end
            ST_FIRE: begin
                if (halt)            state_d = ST_OFF; // HALT
                else if (pulse_last) state_d = ST_RUN; // DONE
            end
        endcase
    end

    // outputs
    always_comb begin
        warn_set = (state_q == ST_RUN)  && !halt && !kick && hit_warn;
        fire_set = (state_q == ST_WARN) && !halt && !kick && hit_end;
        auto_hit = warn_set && auto_feed;
        sys_rst  = (state_q == ST_FIRE);
        counting = ((state_q == ST_RUN) || (state_q == ST_WARN))
                   && !halt && !kick && !auto_hit;
    end

    // cycle counter since last feed
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (counting) cnt_q <= cnt_q + CNT_ONE;
        else               cnt_q <= '0;
    end

endmodule

// File: rtl/guard_wdt_regs.sv
module guard_wdt_regs
    import guard_wdt_pkg::*;
#(
    parameter int          ADDR_W     = 2,
    parameter int          DATA_W     = 32,
    parameter int          PULSE_W    = 10,
    parameter int          INIT_LEN   = 16,
    parameter logic [31:0] UNLOCK_KEY = 32'h1D0C_5EA1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic               warn_set,
    input  logic               fire_set,
    output logic               halt,
    output logic               auto_feed,
    output logic [PULSE_W-1:0] pulse_len,
    output logic               kick,
    output logic               irq_st
);

    localparam int LEN_MSB = CTRL_LEN_LSB + PULSE_W - 1;
    localparam int KICK_B  = LEN_MSB + 1;
    localparam int CLR_B   = LEN_MSB + 2;

    logic        halt_q, auto_q, irq_q, flag_q, unlocked, ctrl_wr, clr;
    logic [PULSE_W-1:0] len_q;
    logic [31:0] lock_q;

    assign unlocked = (lock_q == UNLOCK_KEY);
    assign ctrl_wr  = wr_en && (addr == ADDR_W'(ADDR_CTRL)) && unlocked;
    assign kick     = ctrl_wr && wdata[KICK_B];
    assign clr      = ctrl_wr && wdata[CLR_B];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            halt_q <= 1'b0;
            auto_q <= 1'b0;
            len_q  <= PULSE_W'(INIT_LEN);
            lock_q <= '0;
            irq_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            if (wr_en && (addr == ADDR_W'(ADDR_LOCK))) lock_q <= wdata[31:0];
            if (ctrl_wr) begin
                halt_q <= wdata[CTRL_HALT_B];
                auto_q <= wdata[CTRL_AUTO_B];
                len_q  <= wdata[LEN_MSB:CTRL_LEN_LSB];
            end
            if (halt_q || kick) irq_q <= 1'b0;
            else if (warn_set)  irq_q <= 1'b1;
            if (fire_set)       flag_q <= 1'b1;
            else if (clr)       flag_q <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(ADDR_CTRL): begin
                rdata[CTRL_HALT_B]          = halt_q;
                rdata[CTRL_AUTO_B]          = auto_q;
                rdata[LEN_MSB:CTRL_LEN_LSB] = len_q;
            end
            ADDR_W'(ADDR_STATUS): begin
                rdata[STAT_FLAG_B] = flag_q;
                rdata[STAT_IRQ_B]  = irq_q;
            end
            ADDR_W'(ADDR_LOCK): rdata[0] = unlocked;
            default: rdata = '0;
        endcase
    end

    assign halt      = halt_q;
    assign auto_feed = auto_q;
    assign pulse_len = len_q;
    assign irq_st    = irq_q;

endmodule

// File: rtl/guard_wdt.sv
module guard_wdt #(
    parameter int          CNT_W      = 16,
    parameter int          PULSE_W    = 10,
    parameter int          INIT_LEN   = 16,
    parameter int          ADDR_W     = 2,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] UNLOCK_KEY = 32'h1D0C_5EA1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq_o,
    output logic              sys_rst_o
);

    logic halt, auto_feed, kick, warn_set, fire_set, pulse_last;
    logic [PULSE_W-1:0] pulse_len;

    guard_wdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_W(PULSE_W),
        .INIT_LEN(INIT_LEN), .UNLOCK_KEY(UNLOCK_KEY)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .warn_set(warn_set), .fire_set(fire_set),
        .halt(halt), .auto_feed(auto_feed), .pulse_len(pulse_len),
        .kick(kick), .irq_st(irq_o)
    );

    guard_wdt_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .halt(halt), .auto_feed(auto_feed),
        .kick(kick), .pulse_last(pulse_last), .warn_set(warn_set),
        .fire_set(fire_set), .sys_rst(sys_rst_o)
    );

    guard_wdt_pulse #(.PULSE_W(PULSE_W)) u_pulse (
        .clk(clk), .rst_n(rst_n), .load(fire_set), .len(pulse_len),
        .last(pulse_last)
    );

endmodule

// File: rtl/guard_wdt_chk.sv
module guard_wdt_chk #(
    parameter int          ADDR_W     = 2,
    parameter int          DATA_W     = 32,
    parameter int          PULSE_W    = 10,
    parameter logic [31:0] UNLOCK_KEY = 32'h1D0C_5EA1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  addr,
    input logic [DATA_W-1:0]  wdata,
    input logic               kick,
    input logic               clr,
    input logic               fire_set,
    input logic               halt,
    input logic               auto_feed,
    input logic [PULSE_W-1:0] pulse_len,
    input logic               flag,
    input logic               irq_o,
    input logic               sys_rst_o
);

    // independent model of the lock state, tracked from the bus
    logic open_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else if (wr_en && addr == ADDR_W'(2)) open_q <= (wdata[31:0] == UNLOCK_KEY);
    end

    AST_KICK_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        kick |-> !fire_set);                                             // R5
    AST_WARN_BEFORE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_set |-> irq_o);                                             // R3
    AST_FIRE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_set |=> sys_rst_o);                                         // R4
    AST_FLAG_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        fire_set |=> flag);                                              // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);                                        // R7
    AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (!sys_rst_o && !irq_o));                                // R9
    AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(0) && !open_q)
            |=> ($stable(halt) && $stable(auto_feed) && $stable(pulse_len))); // R2

endmodule

bind guard_wdt guard_wdt_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PULSE_W(PULSE_W), .UNLOCK_KEY(UNLOCK_KEY)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .kick(kick), .clr(u_regs.clr), .fire_set(fire_set), .halt(halt),
    .auto_feed(auto_feed), .pulse_len(pulse_len), .flag(u_regs.flag_q),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o)
);

// File: tb/test_guard_wdt.sv
module test_guard_wdt;

    localparam int          CNT_W = 8;
    localparam int          T     = 1 << CNT_W;
    localparam int          WA    = (T / 4) * 3;
    localparam logic [31:0] KEY   = 32'h1D0C_5EA1;
    localparam int          EV_IRQ = 0;
    localparam int          EV_RST = 1;
    localparam logic [31:0] KICK  = 32'h1000;
    localparam logic [31:0] CLR   = 32'h2000;

    typedef struct { int kind; int at; int width; } ev_t;

    logic        clk = 0, rst_n = 0, wr_en = 0;
    logic [1:0]  addr = 0;
    logic [31:0] wdata = 0, rdata;
    logic        irq_o, sys_rst_o;

    int   cyc = 0, n_checks = 0, errors = 0;
    ev_t  exp_q[$];
    bit   irq_d = 0, rst_d = 0;
    int   rise_at = 0;

    guard_wdt #(.CNT_W(CNT_W), .UNLOCK_KEY(KEY)) i_guard_wdt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .irq_o(irq_o), .sys_rst_o(sys_rst_o)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d, output int at);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk); wr_en = 0; at = cyc;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk); addr = a; #1; v = rdata;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic push(input int kind, input int at, input int width);
        ev_t e;
        e.kind = kind; e.at = at; e.width = width;
        exp_q.push_back(e);
    endtask

    // monitor: compares observed events against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_o && !irq_d) begin
                if (exp_q.size() == 0 || exp_q[0].kind != EV_IRQ)
                    chk(0, "R3/R6 unexpected irq rise at cycle", cyc, -1);
                else begin
                    chk(exp_q[0].at == cyc, "R3 irq rise cycle", cyc, exp_q[0].at);
                    void'(exp_q.pop_front());
                end
            end
            if (sys_rst_o && !rst_d) rise_at = cyc;
            if (!sys_rst_o && rst_d) begin
                if (exp_q.size() == 0 || exp_q[0].kind != EV_RST)
                    chk(0, "R4/R5/R6/R9 unexpected reset pulse at cycle", rise_at, -1);
                else begin
                    chk(exp_q[0].at == rise_at, "R4 reset start cycle", rise_at, exp_q[0].at);
                    chk(exp_q[0].width == cyc - rise_at, "R4 reset width", cyc - rise_at, exp_q[0].width);
                    void'(exp_q.pop_front());
                end
            end
            irq_d = irq_o;
            rst_d = sys_rst_o;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): cycles %0d expected < %0d", cyc, 200000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int e;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        chk(sys_rst_o == 0, "R1 sys_rst_o", sys_rst_o, 0);
        chk(irq_o == 0, "R1 irq_o", irq_o, 0);
        rd(2'd1, v); chk(v == 0, "R1 STATUS", v, 0);
        rd(2'd2, v); chk(v == 0, "R1 LOCK", v, 0);
        rd(2'd0, v); chk(v == 32'd64, "R1 CTRL", v, 64);

        // R2 locked write ignored
        wr(2'd0, 32'h1, e);
        rd(2'd0, v); chk(v == 32'd64, "R2 locked CTRL write", v, 64);
        wr(2'd2, KEY, e);
        rd(2'd2, v); chk(v == 1, "R2 LOCK unlocked", v, 1);

        // R10 STATUS writes ignored
        wr(2'd1, 32'h3, e);
        rd(2'd1, v); chk(v == 0, "R10 STATUS write", v, 0);

        // R3 R4 R7: unfed watchdog fires twice
        wr(2'd0, (32'd5 << 2) | KICK, e);
        push(EV_IRQ, e + WA, 0);
        push(EV_RST, e + T, 5);
        push(EV_RST, e + T + 5 + T, 5);
        wait_to(e + 2 * T + 5 + 8);
        rd(2'd1, v); chk(v == 3, "R7 STATUS flag and irq after fire", v, 3);
        rd(2'd0, v); chk(v == 32'd20, "R8 CTRL reads kick/clear as 0", v, 20);
        wr(2'd0, (32'd5 << 2) | KICK | CLR, e);
        rd(2'd1, v); chk(v == 0, "R7 flag cleared, R5 irq cleared", v, 0);

        // R5 periodic kicks keep it quiet
        for (int i = 0; i < 6; i++) begin
            repeat (100) @(negedge clk);
            wr(2'd0, (32'd5 << 2) | KICK, e);
        end
        chk(exp_q.size() == 0 && sys_rst_o == 0, "R5 no event while fed", exp_q.size(), 0);

        // R9 halt
        wr(2'd0, (32'd5 << 2) | 32'h1, e);
        repeat (2 * T) @(negedge clk);
        chk(sys_rst_o == 0 && irq_o == 0, "R9 quiet while halted", {sys_rst_o, irq_o}, 0);
        wr(2'd0, (32'd5 << 2), e);
        push(EV_IRQ, e + 1 + WA, 0);
        wait_to(e + 1 + WA + 8);
        // R5 kick during warning prevents reset
        wr(2'd0, (32'd5 << 2) | KICK, e);
        chk(irq_o == 0, "R5 kick clears irq", irq_o, 0);
        repeat (WA - 20) @(negedge clk);
        chk(exp_q.size() == 0, "R5 no pending events", exp_q.size(), 0);

        // R6 auto-feed
        wr(2'd0, (32'd5 << 2) | 32'h2 | KICK, e);
        push(EV_IRQ, e + WA, 0);
        repeat (3 * T) @(negedge clk);
        rd(2'd1, v); chk(v == 2, "R6 irq set, no fire under auto-feed", v, 2);
        chk(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        // R4 zero length gives one cycle
        wr(2'd0, KICK, e);
        push(EV_IRQ, e + WA, 0);
        push(EV_RST, e + T, 1);
        wait_to(e + T + 6);
        wr(2'd0, KICK | CLR, e);

        // R2 relock
        wr(2'd2, 32'h0, e);
        wr(2'd0, 32'h1, e);
        rd(2'd0, v); chk(v == 0, "R2 relocked CTRL write", v, 0);
        rd(2'd2, v); chk(v == 0, "R2 LOCK relocked", v, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3/R4 all predicted events seen", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, errors);
        $finish;
    end

endmodule